// File: doc/BRIEF.md
# Ancillary Packet Identifier Filter

This block sits in a 10-bit video word stream and decides, packet by packet, whether ancillary data may go on to a downstream FIFO. An ancillary packet opens with the three-word start marker 000h, 3FFh, 3FFh. The marker is followed by a primary identifier word, a secondary identifier word (a secondary ID or a block number), a data count word, that many user words, and a checksum word. The block compares the low bytes of the two identifier words with a programmable 16-bit identifier. A 16-bit mask selects which bits take part in the comparison.

The stream is delayed by five accepted words. When the first marker word leaves the block, both identifier words are already inside the delay line, so the decision is known in advance. That decision is driven on `out_admit` for every word of the packet, from the first marker word to the checksum. Words outside any packet leave with `out_admit` high. The delay is counted in accepted words, not in clock cycles, so gaps in `in_valid` have no effect on the result.

Top module: `anc_id_filter`

## Requirements
- R1: Every word accepted with `in_valid` high leaves unchanged on `out_word`, in the same order. Word n is output with `out_valid` high for one cycle, in the cycle after the clock edge that accepts word n+5.
- R2: A word that is not part of an ancillary packet leaves with `out_admit` = 1.
- R3: A packet is admitted when both of these hold. First, for every bit b in 0..7 where `id_mask[b]` = 1, bit b of the primary identifier (the 4th packet word) equals `id_value[b]`. Second, for every b where `id_mask[8+b]` = 1, bit b of the secondary identifier (the 5th packet word) equals `id_value[8+b]`. A mask bit of 0 means that bit is not compared. The identifier and mask are sampled when the first marker word leaves the block.
- R4: With `id_mask` = 0, every packet leaves with `out_admit` = 1.
- R5: Bits 9:8 of the two identifier words do not affect the decision.
- R6: A packet spans 7 + C words, where C is bits 7:0 of its 6th word (the data count). It starts at a 000h word that is followed by two 3FFh words. All words of the packet leave with the same `out_admit` value.
- R7: The word that follows the last word of a packet leaves with `out_admit` = 1, unless it starts a new packet.
- R8: A start marker that appears before the current packet has ended ends that packet. A new decision and a new span are taken from the new packet.
- R9: After reset, `out_valid` is 0 and `out_admit` is 1. No word is output until six words have been accepted.
- R10: Idle cycles between accepted words, whatever their number and position, do not change the words that are output or their admit values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accept `in_word` this cycle |
| in_word | input | 10 | Incoming video word |
| id_value | input | 16 | Identifier to match: bits 7:0 primary, bits 15:8 secondary |
| id_mask | input | 16 | Compare-enable mask, 1 = compare the bit |
| out_valid | output | 1 | Output word valid |
| out_word | output | 10 | Delayed video word |
| out_admit | output | 1 | 1 = this word may be loaded downstream |

## Verification
The bench targets packets with a data count of zero and of 255. A span counter that is off by one would leak a rejected packet's checksum as admitted, or reject the first video word after the packet. Identifiers differing only in bits 9:8, single-bit mismatches in either identifier byte and masks that hide the mismatching bit each catch a design that compares the wrong byte, the parity bits or the mask polarity. A second marker in the middle of a packet, back-to-back packets with opposite decisions, and runs with random idle gaps catch a design that ignores a restart, carries a decision over into the next packet, or counts clock cycles instead of words.

// File: rtl/anc_id_filter.sv
module anc_id_filter #(
  parameter int WORD_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [WORD_W-1:0]     in_word,
  input  logic [2*BYTE_W-1:0]   id_value,
  input  logic [2*BYTE_W-1:0]   id_mask,
  output logic                  out_valid,
  output logic [WORD_W-1:0]     out_word,
  output logic                  out_admit
);
  localparam int DEPTH = 5;
  localparam int CNT_W = BYTE_W + 1;
  localparam logic [WORD_W-1:0] MARK_LO = '0;
  localparam logic [WORD_W-1:0] MARK_HI = '1;
  localparam logic [CNT_W-1:0]  FIXED_TAIL = CNT_W'(6);

  logic [WORD_W-1:0] line [DEPTH];
  logic [DEPTH-1:0]  full;
  logic [CNT_W-1:0]  remain;
  logic              pkt_ok;
  logic              out_sop;

  wire sop = (&full) && line[DEPTH-1] == MARK_LO &&
             line[DEPTH-2] == MARK_HI && line[DEPTH-3] == MARK_HI;

  wire pri_ok = ((line[1][BYTE_W-1:0] ^ id_value[BYTE_W-1:0]) &
                 id_mask[BYTE_W-1:0]) == '0;
  wire sec_ok = ((line[0][BYTE_W-1:0] ^ id_value[2*BYTE_W-1:BYTE_W]) &
                 id_mask[2*BYTE_W-1:BYTE_W]) == '0;
  wire match  = pri_ok && sec_ok;

  wire [CNT_W-1:0] span_left = {1'b0, in_word[BYTE_W-1:0]} + FIXED_TAIL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) line[k] <= '0;
      full      <= '0;
      remain    <= '0;
      pkt_ok    <= 1'b1;
      out_sop   <= 1'b0;
      out_valid <= 1'b0;
      out_word  <= '0;
      out_admit <= 1'b1;
    end else if (in_valid) begin
      line[0] <= in_word;
      for (int k = 1; k < DEPTH; k++) line[k] <= line[k-1];
      full      <= {full[DEPTH-2:0], 1'b1};
      out_valid <= full[DEPTH-1];
      out_word  <= line[DEPTH-1];
      out_sop   <= sop;
      if (sop) begin
        out_admit <= match;
        pkt_ok    <= match;
        remain    <= span_left;
      end else if (full[DEPTH-1]) begin
        if (remain != '0) begin
          out_admit <= pkt_ok;
          remain    <= remain - 1'b1;
        end else begin
          out_admit <= 1'b1;
        end
      end
    end else begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/anc_id_filter_chk.sv
module anc_id_filter_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [2*BYTE_W-1:0] id_mask,
  input logic                out_valid,
  input logic                out_admit,
  input logic                out_sop,
  input logic [BYTE_W:0]     remain
);
  logic [2:0] seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (in_valid && seen != 3'd5) seen <= seen + 1'b1;
  end

  p_valid_needs_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  p_no_early_output_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(seen) == 3'd5));

  p_outside_admit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sop && $past(remain) == '0) |-> out_admit);

  p_zero_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop && $past(id_mask) == '0) |-> out_admit);

  p_admit_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_admit));
endmodule

bind anc_id_filter anc_id_filter_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .id_mask(id_mask),
  .out_valid(out_valid), .out_admit(out_admit), .out_sop(out_sop),
  .remain(remain)
);

// File: tb/anc_id_filter_test.sv
`timescale 1ns/1ps
module anc_id_filter_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [9:0]  in_word = '0;
  logic [15:0] id_value = '0;
  logic [15:0] id_mask = '0;
  logic        out_valid;
  logic [9:0]  out_word;
  logic        out_admit;

  anc_id_filter uut (.*);

  always #2 clk = ~clk;

  int vectors = 0, errors = 0;
  string phase = "R9";
  bit run = 0;
  int gapmax = 0;

  logic [9:0] q[$];
  int  m_rem = 0;
  bit  m_pkt = 1;
  bit  e_valid = 0;
  logic [9:0] e_word = '0;
  bit  e_admit = 1;

  function automatic bit id_match(logic [9:0] p, logic [9:0] s);
    for (int b = 0; b < 8; b++) begin
      if (id_mask[b] && p[b] != id_value[b]) return 0;
      if (id_mask[8+b] && s[b] != id_value[8+b]) return 0;
    end
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_rem = 0; m_pkt = 1; e_valid = 0; e_admit = 1;
    end else if (in_valid) begin
      q.push_back(in_word);
      if (q.size() == 6) begin
        e_word = q.pop_front();
        e_valid = 1;
        if (e_word == 10'h000 && q[0] == 10'h3FF && q[1] == 10'h3FF) begin
          m_pkt = id_match(q[2], q[3]);
          m_rem = 6 + int'(q[4][7:0]);
          e_admit = m_pkt;
        end else if (m_rem > 0) begin
          e_admit = m_pkt; m_rem--;
        end else e_admit = 1;
      end else e_valid = 0;
    end else e_valid = 0;
  end

  always @(negedge clk) if (run) begin
    vectors++;
    if (out_valid !== e_valid || (e_valid &&
        (out_word !== e_word || out_admit !== e_admit))) begin
      errors++;
      $display("FAIL %s: valid/word/admit got %b/%h/%b expected %b/%h/%b",
               phase, out_valid, out_word, out_admit, e_valid, e_word, e_admit);
    end
  end

  task automatic put(input logic [9:0] w);
    @(posedge clk); #1; in_valid = 1; in_word = w;
    if (gapmax > 0) repeat ($urandom_range(gapmax, 0)) begin
      @(posedge clk); #1; in_valid = 0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; in_valid = 0; end
  endtask

  task automatic video(input int n);
    for (int k = 0; k < n; k++) put(10'h040 + 10'(k & 8'hFF));
  endtask

  task automatic pkt(input logic [9:0] p, input logic [9:0] s,
                     input int dc, input int cut);
    put(10'h000); put(10'h3FF); put(10'h3FF); put(p); put(s);
    put({2'b01, 8'(dc)});
    for (int k = 0; k < dc && k < cut; k++) put({2'b01, 8'(k)});
    if (cut >= dc) put(10'h155);
  endtask

  initial begin
    idle(3);
    vectors++;
    if (out_valid !== 1'b0 || out_admit !== 1'b1) begin
      errors++;
      $display("FAIL R9: reset valid/admit got %b/%b expected 0/1",
               out_valid, out_admit);
    end
    #1 rst_n = 1;
    run = 1;
    phase = "R9"; video(5); idle(4);
    phase = "R1"; video(12);
    phase = "R2"; video(20); idle(3);
    id_value = 16'h1234; id_mask = 16'hFFFF;
    phase = "R3"; pkt(10'h134, 10'h112, 3, 99); video(3);
    pkt(10'h135, 10'h112, 3, 99); video(3);
    pkt(10'h134, 10'h113, 3, 99); video(3);
    id_mask = 16'hFEFF; pkt(10'h134, 10'h113, 2, 99); video(3);
    id_mask = 16'hFFFE; pkt(10'h135, 10'h112, 2, 99); video(6);
    phase = "R5"; id_mask = 16'hFFFF;
    pkt(10'h234, 10'h212, 1, 99); pkt(10'h034, 10'h312, 1, 99); video(6);
    phase = "R4"; id_mask = 16'h0000;
    pkt(10'h2A5, 10'h15A, 4, 99); pkt(10'h100, 10'h1FF, 0, 99); video(6);
    phase = "R6"; id_mask = 16'hFFFF;
    pkt(10'h100, 10'h100, 0, 99); video(2);
    pkt(10'h100, 10'h100, 255, 999); video(2);
    pkt(10'h134, 10'h112, 255, 999); video(6);
    phase = "R7";
    pkt(10'h101, 10'h112, 2, 99); pkt(10'h134, 10'h112, 1, 99);
    pkt(10'h101, 10'h112, 0, 99); video(6);
    phase = "R8";
    pkt(10'h101, 10'h112, 10, 3); pkt(10'h134, 10'h112, 2, 99); video(4);
    pkt(10'h134, 10'h112, 10, 2); pkt(10'h101, 10'h112, 2, 99); video(6);
    phase = "R10"; gapmax = 3;
    for (int r = 0; r < 20; r++) begin
      id_mask = (r % 3 == 0) ? 16'h0000 : 16'hFFFF;
      pkt((r % 2) ? 10'h134 : 10'h177, 10'h112, r % 7, (r % 5 == 0) ? 2 : 99);
      video(r % 4);
    end
    gapmax = 0; video(8); idle(4);
    run = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule